// File: doc/BRIEF.md
# Legacy I/O Controller Configuration Port

This block is the configuration front end of a multi-function legacy I/O controller. A host reaches it through a two-byte window. An access with the select bit low goes to an index register, and an access with the select bit high goes to a data register. The index picks one of three 8-bit configuration registers: function enable (index 0), function address (index 1) and power/test (index 2). While the identification sequence is still running, reads of the index register return two fixed ID bytes before they return the index.

From the three registers the block continuously decodes the enable, I/O base address and interrupt number of each function it controls. These are one parallel port, two serial ports, a floppy controller and a disk controller with primary and secondary ranges. On reset the registers load from constant tables selected by a 5-bit strap input. Host accesses arrive as single-byte requests on a valid/ready channel. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. Every accepted read produces exactly one response on a valid/ready channel. `req_ready` falls while a response is held and `rsp_ready` is low, so at most one read is in flight. A response holds its data unchanged until `rsp_ready` takes it. Writes produce no response.

Top module: `sio_cfg_port`

## Requirements
- R1: A synchronous active-high reset clears the index to 0, restarts the ID sequence and loads the three registers from tables addressed by the strap. Strap 1 gives enable 0x4F, address 0x11, power/test 0x00. Strap 11 gives 0x4B, 0x08, 0x00. Strap 31 gives 0x00, 0x10, 0x02.
- R2: While `rsp_valid` is high and `rsp_ready` is low, `req_ready` is low and `rsp_rdata` holds its value. Each accepted read yields one response, in request order.
- R3: After reset the first index read returns 0x88 and the second returns 0x00. Later index reads return the index. An index write ends the sequence at once.
- R4: An index write (select 0) stores the full 8-bit value, and later index reads return it.
- R5: A data write (select 1) with index 0, 1 or 2 replaces that register. A data read returns it. Decoded outputs follow on the next cycle.
- R6: With index 3 or above, data reads return 0x00 and data writes change no register.
- R7: Enable bits: bit0 parallel, bit1 serial 0, bit2 serial 1, bit3 floppy, bit6 disk.
- R8: Parallel base from address bits [1:0]: 0→0x378, 1→0x3BC, 2→0x278, 3→0x000. The IRQ is 0→(power/test bit3 ? 7 : 5), 1→7, 2→5, 3→0.
- R9: Serial port n uses address bits [2n+3:2n+2]. Code 0→0x3F8 and code 1→0x2F8. Codes 2 and 3 index a column by address bits [7:6]. Code 2 uses the row 0x3E8, 0x338, 0x2E8, 0x220. Code 3 uses the row 0x2E8, 0x238, 0x2E0, 0x228.
- R10: Serial IRQ is 3 for an odd address code and 4 for an even one.
- R11: Floppy base is 0x370 when enable bit5 is set and 0x3F0 otherwise. Floppy IRQ is 6.
- R12: Disk primary base is 0x170 when enable bit7 is set and 0x1F0 otherwise. The secondary base is primary + 0x206. Disk IRQ is 14.
- R13: The strap is sampled only during reset. Changing it afterwards has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strap_cfg | input | 5 | Reset table selector |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request can be accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_sel_data | input | 1 | 0 = index register, 1 = data register |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_rdata | output | 8 | Read byte |
| par_en | output | 1 | Parallel enable |
| par_base | output | 16 | Parallel base |
| par_irq | output | 4 | Parallel IRQ |
| ser_en | output | 2 | Serial enables, bit n = port n |
| ser_base | output | 32 | Serial bases, port n at [16n+15:16n] |
| ser_irq | output | 8 | Serial IRQs, port n at [4n+3:4n] |
| fdc_en | output | 1 | Floppy enable |
| fdc_base | output | 16 | Floppy base |
| fdc_irq | output | 4 | Floppy IRQ |
| ide_en | output | 1 | Disk enable |
| ide_base | output | 16 | Disk primary base |
| ide_alt_base | output | 16 | Disk secondary base |
| ide_irq | output | 4 | Disk IRQ |

## Verification
The hardest situation to reach is a read response stalled by the consumer while more reads are queued. The ID sequence and the index then have to keep their order even though requests are refused for several cycles. The bench drives `rsp_ready` from a pseudo-random bit pattern and keeps reads back to back, alternating index and data reads. It also resets into a strap value and writes the index before any index read, which cuts the ID sequence short.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;

  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned STRAP_W   = 5;
  localparam int unsigned NUM_REGS  = 3;
  localparam logic [7:0]  ID_FIRST  = 8'h88;
  localparam logic [7:0]  ID_SECOND = 8'h00;

  typedef enum logic [1:0] {
    ID_HI   = 2'd0,
    ID_LO   = 2'd1,
    ID_DONE = 2'd2
  } id_step_t;

  function automatic logic [7:0] enable_reset(input logic [STRAP_W-1:0] s);
    if (s <= 5'd5)       return 8'h4F;
    else if (s <= 5'd11) return 8'h4B;
    else if (s <= 5'd15) return 8'h0F;
    else if (s <= 5'd19) return 8'h49;
    else if (s <= 5'd23) return 8'h07;
    else if (s <= 5'd29) return 8'h47;
    else if (s == 5'd30) return 8'h08;
    else                 return 8'h00;
  endfunction

  function automatic logic [7:0] address_reset(input logic [STRAP_W-1:0] s);
    case (s)
      5'd0, 5'd12, 5'd20, 5'd24, 5'd30, 5'd31: return 8'h10;
      5'd1, 5'd2, 5'd13, 5'd21, 5'd25, 5'd26:  return 8'h11;
      5'd3, 5'd14, 5'd22, 5'd27:               return 8'h39;
      5'd4, 5'd15, 5'd23, 5'd28:               return 8'h24;
      5'd5, 5'd29:                             return 8'h38;
      5'd7, 5'd8, 5'd17, 5'd18:                return 8'h01;
      5'd9:                                    return 8'h09;
      5'd10, 5'd11:                            return 8'h08;
      default:                                 return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] power_reset(input logic [STRAP_W-1:0] s);
    return (s == 5'd31) ? 8'h02 : 8'h00;
  endfunction

  function automatic logic [7:0] reg_reset(input int unsigned which,
                                           input logic [STRAP_W-1:0] s);
    case (which)
      0:       return enable_reset(s);
      1:       return address_reset(s);
      default: return power_reset(s);
    endcase
  endfunction

  function automatic logic [15:0] serial_base(input logic [1:0] code,
                                              input logic [1:0] col);
    if (code == 2'd0) return 16'h03F8;
    if (code == 2'd1) return 16'h02F8;
    if (code[0] == 1'b0) begin
      case (col)
        2'd0:    return 16'h03E8;
        2'd1:    return 16'h0338;
        2'd2:    return 16'h02E8;
        default: return 16'h0220;
      endcase
    end
    case (col)
      2'd0:    return 16'h02E8;
      2'd1:    return 16'h0238;
      2'd2:    return 16'h02E0;
      default: return 16'h0228;
    endcase
  endfunction

endpackage

// File: rtl/sio_cfg_regs.sv
module sio_cfg_regs
  import sio_cfg_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [STRAP_W-1:0] strap,
  input  logic               acc,
  input  logic               wr,
  input  logic               sel_data,
  input  logic [BYTE_W-1:0]  wdata,
  output logic [BYTE_W-1:0]  rdata,
  output logic               id_fresh,
  output logic [BYTE_W-1:0]  fe,
  output logic [BYTE_W-1:0]  fa,
  output logic [BYTE_W-1:0]  pt
);

  localparam int unsigned SEL_W = $clog2(NUM_REGS);

  logic [BYTE_W-1:0]                idx_q;
  id_step_t                         step_q;
  logic [NUM_REGS-1:0][BYTE_W-1:0]  cfg_q;
  logic                             idx_valid;
  logic                             data_wr;

  assign idx_valid = (idx_q < BYTE_W'(NUM_REGS));
  assign data_wr   = acc && wr && sel_data && idx_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q  <= '0;
      step_q <= ID_HI;
    end else if (acc && !sel_data) begin
      if (wr) begin
        idx_q  <= wdata;
        step_q <= ID_DONE;
      end else begin
        case (step_q)
          ID_HI:   step_q <= ID_LO;
          default: step_q <= ID_DONE;
        endcase
      end
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_cfg
    logic [BYTE_W-1:0] q;
    always_ff @(posedge clk) begin
      if (rst)
        q <= reg_reset(g, strap);
      else if (data_wr && idx_q[SEL_W-1:0] == SEL_W'(g))
        q <= wdata;
    end
    assign cfg_q[g] = q;
  end

  always_comb begin
    if (!sel_data) begin
      case (step_q)
        ID_HI:   rdata = ID_FIRST;
        ID_LO:   rdata = ID_SECOND;
        default: rdata = idx_q;
      endcase
    end else if (idx_valid) begin
      rdata = cfg_q[idx_q[SEL_W-1:0]];
    end else begin
      rdata = '0;
    end
  end

  assign id_fresh = (step_q == ID_HI);
  assign fe = cfg_q[0];
  assign fa = cfg_q[1];
  assign pt = cfg_q[2];

  // Data write with an out-of-range index leaves every register alone (R6)
  assert_oob_write_ignored_R6: assert property (@(posedge clk) disable iff (rst)
    (acc && wr && sel_data && idx_q >= BYTE_W'(NUM_REGS)) |=> $stable(cfg_q));

  // Without a data write the registers hold, whatever the strap does (R13)
  assert_strap_ignored_R13: assert property (@(posedge clk) disable iff (rst)
    !(acc && wr && sel_data) |=> $stable(cfg_q));

  // Index write stores the written byte (R4)
  assert_index_store_R4: assert property (@(posedge clk) disable iff (rst)
    (acc && wr && !sel_data) |=> (idx_q == $past(wdata)));

endmodule

// File: rtl/sio_cfg_rsp.sv
module sio_cfg_rsp
  import sio_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [BYTE_W-1:0] load_data,
  output logic              can_accept,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [BYTE_W-1:0] rsp_rdata
);

  logic              valid_q;
  logic [BYTE_W-1:0] data_q;

  assign can_accept = !valid_q || rsp_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else if (load) begin
      valid_q <= 1'b1;
      data_q  <= load_data;
    end else if (rsp_ready) begin
      valid_q <= 1'b0;
    end
  end

  assign rsp_valid = valid_q;
  assign rsp_rdata = data_q;

  // A stalled response stays presented with unchanged data (R2)
  assert_stall_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

endmodule

// File: rtl/sio_cfg_decode.sv
module sio_cfg_decode
  import sio_cfg_pkg::*;
#(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned IRQ_W   = 4,
  parameter int unsigned NUM_SER = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [BYTE_W-1:0]         fe,
  input  logic [BYTE_W-1:0]         fa,
  input  logic [BYTE_W-1:0]         pt,
  output logic                      par_en,
  output logic [ADDR_W-1:0]         par_base,
  output logic [IRQ_W-1:0]          par_irq,
  output logic [NUM_SER-1:0]        ser_en,
  output logic [NUM_SER*ADDR_W-1:0] ser_base,
  output logic [NUM_SER*IRQ_W-1:0]  ser_irq,
  output logic                      fdc_en,
  output logic [ADDR_W-1:0]         fdc_base,
  output logic [IRQ_W-1:0]          fdc_irq,
  output logic                      ide_en,
  output logic [ADDR_W-1:0]         ide_base,
  output logic [ADDR_W-1:0]         ide_alt_base,
  output logic [IRQ_W-1:0]          ide_irq
);

  localparam int unsigned SER_EN_LSB = 1;
  localparam logic [ADDR_W-1:0] ALT_OFFSET = ADDR_W'(16'h0206);

  logic unused_bits;
  assign unused_bits = ^{fe[4], pt[7:4], pt[2:0]};

  // Parallel port
  assign par_en = fe[0];
  always_comb begin
    case (fa[1:0])
      2'd0: begin
        par_base = ADDR_W'(16'h0378);
        par_irq  = pt[3] ? IRQ_W'(7) : IRQ_W'(5);
      end
      2'd1: begin
        par_base = ADDR_W'(16'h03BC);
        par_irq  = IRQ_W'(7);
      end
      2'd2: begin
        par_base = ADDR_W'(16'h0278);
        par_irq  = IRQ_W'(5);
      end
      default: begin
        par_base = '0;
        par_irq  = '0;
      end
    endcase
  end

  // Serial ports
  for (genvar n = 0; n < NUM_SER; n++) begin : g_ser
    logic [1:0] code;
    assign code = fa[2*n+3 -: 2];
    assign ser_en[n] = fe[SER_EN_LSB+n];
    assign ser_base[n*ADDR_W +: ADDR_W] = ADDR_W'(serial_base(code, fa[7:6]));
    assign ser_irq[n*IRQ_W +: IRQ_W]    = code[0] ? IRQ_W'(3) : IRQ_W'(4);
  end

  // Floppy controller
  assign fdc_en   = fe[3];
  assign fdc_base = fe[5] ? ADDR_W'(16'h0370) : ADDR_W'(16'h03F0);
  assign fdc_irq  = IRQ_W'(6);

  // Disk controller
  assign ide_en       = fe[6];
  assign ide_base     = fe[7] ? ADDR_W'(16'h0170) : ADDR_W'(16'h01F0);
  assign ide_alt_base = fe[7] ? ADDR_W'(16'h0376) : ADDR_W'(16'h03F6);
  assign ide_irq      = IRQ_W'(14);

  // Secondary disk range sits at the fixed offset from the primary (R12)
  assert_disk_alt_R12: assert property (@(posedge clk) disable iff (rst)
    ide_alt_base == ide_base + ALT_OFFSET);

  // A parallel port without an address carries no interrupt (R8)
  assert_par_none_R8: assert property (@(posedge clk) disable iff (rst)
    (par_base == '0) |-> (par_irq == '0));

endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
  import sio_cfg_pkg::*;
#(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned IRQ_W   = 4,
  parameter int unsigned NUM_SER = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [STRAP_W-1:0]        strap_cfg,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic                      req_write,
  input  logic                      req_sel_data,
  input  logic [BYTE_W-1:0]         req_wdata,
  output logic                      rsp_valid,
  input  logic                      rsp_ready,
  output logic [BYTE_W-1:0]         rsp_rdata,
  output logic                      par_en,
  output logic [ADDR_W-1:0]         par_base,
  output logic [IRQ_W-1:0]          par_irq,
  output logic [NUM_SER-1:0]        ser_en,
  output logic [NUM_SER*ADDR_W-1:0] ser_base,
  output logic [NUM_SER*IRQ_W-1:0]  ser_irq,
  output logic                      fdc_en,
  output logic [ADDR_W-1:0]         fdc_base,
  output logic [IRQ_W-1:0]          fdc_irq,
  output logic                      ide_en,
  output logic [ADDR_W-1:0]         ide_base,
  output logic [ADDR_W-1:0]         ide_alt_base,
  output logic [IRQ_W-1:0]          ide_irq
);

  logic              acc;
  logic [BYTE_W-1:0] rd_byte;
  logic              id_fresh;
  logic [BYTE_W-1:0] fe, fa, pt;

  assign acc = req_valid && req_ready;

  sio_cfg_regs u_regs (
    .clk      (clk),
    .rst      (rst),
    .strap    (strap_cfg),
    .acc      (acc),
    .wr       (req_write),
    .sel_data (req_sel_data),
    .wdata    (req_wdata),
    .rdata    (rd_byte),
    .id_fresh (id_fresh),
    .fe       (fe),
    .fa       (fa),
    .pt       (pt)
  );

  sio_cfg_rsp u_rsp (
    .clk        (clk),
    .rst        (rst),
    .load       (acc && !req_write),
    .load_data  (rd_byte),
    .can_accept (req_ready),
    .rsp_valid  (rsp_valid),
    .rsp_ready  (rsp_ready),
    .rsp_rdata  (rsp_rdata)
  );

  sio_cfg_decode #(
    .ADDR_W  (ADDR_W),
    .IRQ_W   (IRQ_W),
    .NUM_SER (NUM_SER)
  ) u_dec (
    .clk          (clk),
    .rst          (rst),
    .fe           (fe),
    .fa           (fa),
    .pt           (pt),
    .par_en       (par_en),
    .par_base     (par_base),
    .par_irq      (par_irq),
    .ser_en       (ser_en),
    .ser_base     (ser_base),
    .ser_irq      (ser_irq),
    .fdc_en       (fdc_en),
    .fdc_base     (fdc_base),
    .fdc_irq      (fdc_irq),
    .ide_en       (ide_en),
    .ide_base     (ide_base),
    .ide_alt_base (ide_alt_base),
    .ide_irq      (ide_irq)
  );

  // First index read after reset answers with the leading ID byte (R3)
  assert_id_first_R3: assert property (@(posedge clk) disable iff (rst)
    (acc && !req_write && !req_sel_data && id_fresh) |=>
      (rsp_valid && rsp_rdata == ID_FIRST));

endmodule

// File: tb/sio_cfg_port_test.sv
`timescale 1ns/1ps
module sio_cfg_port_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  strap_cfg = 5'd1;
  logic        req_valid = 1'b0, req_write = 1'b0, req_sel_data = 1'b0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, rsp_valid, rsp_ready;
  logic [7:0]  rsp_rdata;
  logic        par_en, fdc_en, ide_en;
  logic [1:0]  ser_en;
  logic [15:0] par_base, fdc_base, ide_base, ide_alt_base;
  logic [31:0] ser_base;
  logic [3:0]  par_irq, fdc_irq, ide_irq;
  logic [7:0]  ser_irq;

  sio_cfg_port uut (.*);

  always #2 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       stall_mode = 1'b0;
  logic [7:0] lfsr = 8'h5A;

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (stall_mode) begin
      lfsr      <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      rsp_ready <= lfsr[0];
    end else begin
      rsp_ready <= 1'b1;
    end
  end

  // Monitor: compares responses against the scoreboard queue
  always @(negedge clk) begin
    #1;
    if (!rst) begin
      if (rsp_valid && !rsp_ready) chk("R2 ready low while stalled", req_ready, 1'b0);
      if (rsp_valid && rsp_ready) begin
        if (exp_q.size() == 0) begin
          chk("R2 unexpected response", 1'b1, 1'b0);
        end else begin
          logic [7:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(t, rsp_rdata, e);
        end
      end
    end
  end

  task automatic access(input logic wr, input logic sel, input logic [7:0] d,
                        input logic [7:0] exp, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_sel_data = sel; req_wdata = d;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    if (!wr) begin exp_q.push_back(exp); tag_q.push_back(tag); end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wr_idx(input logic [7:0] v);  access(1'b1, 1'b0, v, 8'h00, ""); endtask
  task automatic wr_dat(input logic [7:0] v);  access(1'b1, 1'b1, v, 8'h00, ""); endtask
  task automatic rd_idx(input logic [7:0] e, input string t); access(1'b0, 1'b0, 8'h00, e, t); endtask
  task automatic rd_dat(input logic [7:0] e, input string t); access(1'b0, 1'b1, 8'h00, e, t); endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset(input logic [4:0] s);
    drain();
    @(negedge clk);
    rst = 1'b1; strap_cfg = s;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    #1;
  endtask

  task automatic chk_ser(input string r, input int n, input logic [15:0] b, input logic [3:0] q);
    #1;
    chk(r, ser_base[n*16 +: 16], b);
    chk(r, ser_irq[n*4 +: 4], q);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    // R1: reset with strap 1 -> enable 0x4F, address 0x11, power 0x00
    do_reset(5'd1);
    chk("R1 rsp_valid after reset", rsp_valid, 1'b0);
    chk("R7 par_en", par_en, 1'b1);
    chk("R7 ser_en", ser_en, 2'b11);
    chk("R7 fdc_en", fdc_en, 1'b1);
    chk("R7 ide_en", ide_en, 1'b1);
    chk("R8 par_base code1", par_base, 16'h03BC);
    chk("R8 par_irq code1", par_irq, 4'd7);
    chk_ser("R9 ser0 code0", 0, 16'h03F8, 4'd4);
    chk_ser("R10 ser1 code1", 1, 16'h02F8, 4'd3);
    chk("R11 fdc_base", fdc_base, 16'h03F0);
    chk("R11 fdc_irq", fdc_irq, 4'd6);
    chk("R12 ide_base", ide_base, 16'h01F0);
    chk("R12 ide_alt", ide_alt_base, 16'h03F6);
    chk("R12 ide_irq", ide_irq, 4'd14);
    // R3: ID sequence
    rd_idx(8'h88, "R3 first id byte");
    rd_idx(8'h00, "R3 second id byte");
    rd_idx(8'h00, "R3 index after id");
    rd_dat(8'h4F, "R1 enable reset");
    wr_idx(8'h01);
    rd_dat(8'h11, "R1 address reset");
    wr_idx(8'h02);
    rd_dat(8'h00, "R1 power reset");
    rd_idx(8'h02, "R4 index readback");
    // R13: strap change outside reset
    strap_cfg = 5'd31;
    repeat (3) @(negedge clk);
    #1;
    chk("R13 par_base stable", par_base, 16'h03BC);
    wr_idx(8'h00);
    rd_dat(8'h4F, "R13 enable unchanged");
    // R5/R7/R11/R12: enable writes
    wr_dat(8'hE9); #1;
    chk("R7 par_en E9", par_en, 1'b1);
    chk("R7 ser_en E9", ser_en, 2'b00);
    chk("R7 fdc_en E9", fdc_en, 1'b1);
    chk("R11 fdc_base alt", fdc_base, 16'h0370);
    chk("R7 ide_en E9", ide_en, 1'b1);
    chk("R12 ide_base alt", ide_base, 16'h0170);
    chk("R12 ide_alt alt", ide_alt_base, 16'h0376);
    rd_dat(8'hE9, "R5 enable readback");
    wr_dat(8'h06); #1;
    chk("R7 par_en 06", par_en, 1'b0);
    chk("R7 ser_en 06", ser_en, 2'b11);
    chk("R7 fdc_en 06", fdc_en, 1'b0);
    chk("R7 ide_en 06", ide_en, 1'b0);
    // R8/R9/R10: address field patterns
    wr_idx(8'h01);
    wr_dat(8'hB8); #1;
    chk("R8 par_base code0", par_base, 16'h0378);
    chk("R8 par_irq code0 bit3=0", par_irq, 4'd5);
    chk_ser("R9 ser0 code2 col2", 0, 16'h02E8, 4'd4);
    chk_ser("R10 ser1 code3 col2", 1, 16'h02E0, 4'd3);
    wr_dat(8'h6E); #1;
    chk("R8 par_base code2", par_base, 16'h0278);
    chk("R8 par_irq code2", par_irq, 4'd5);
    chk_ser("R9 ser0 code3 col1", 0, 16'h0238, 4'd3);
    chk_ser("R10 ser1 code2 col1", 1, 16'h0338, 4'd4);
    wr_dat(8'hFB); #1;
    chk("R8 par_base code3", par_base, 16'h0000);
    chk("R8 par_irq code3", par_irq, 4'd0);
    chk_ser("R9 ser0 code2 col3", 0, 16'h0220, 4'd4);
    chk_ser("R9 ser1 code3 col3", 1, 16'h0228, 4'd3);
    wr_dat(8'h02); #1;
    chk_ser("R9 ser0 code0 col0", 0, 16'h03F8, 4'd4);
    wr_dat(8'h08); #1;
    chk_ser("R9 ser0 code2 col0", 0, 16'h03E8, 4'd4);
    wr_idx(8'h02);
    wr_dat(8'h08);
    wr_idx(8'h01);
    wr_dat(8'hC0); #1;
    chk("R8 par_irq code0 bit3=1", par_irq, 4'd7);
    chk_ser("R9 ser1 code0 col3", 1, 16'h03F8, 4'd4);
    wr_idx(8'h02);
    wr_dat(8'h00); #1;
    chk("R8 par_irq back to 5", par_irq, 4'd5);
    // R6: out-of-range index
    wr_idx(8'h05);
    rd_idx(8'h05, "R4 index 5 readback");
    rd_dat(8'h00, "R6 data read index 5");
    wr_dat(8'hFF); #1;
    chk("R6 par_base unchanged", par_base, 16'h0378);
    chk("R6 ser_en unchanged", ser_en, 2'b11);
    chk("R6 fdc_en unchanged", fdc_en, 1'b0);
    wr_idx(8'h00); rd_dat(8'h06, "R6 enable unchanged");
    wr_idx(8'h01); rd_dat(8'hC0, "R6 address unchanged");
    wr_idx(8'h02); rd_dat(8'h00, "R6 power unchanged");
    wr_idx(8'h03); rd_dat(8'h00, "R6 index 3 reads zero");
    wr_idx(8'hFF); rd_dat(8'h00, "R6 index FF reads zero");
    rd_idx(8'hFF, "R4 index FF readback");
    // R2: back-pressure with back-to-back reads
    wr_idx(8'h01);
    stall_mode = 1'b1;
    for (int i = 0; i < 40; i++) begin
      if (i % 2 == 0) rd_dat(8'hC0, "R2 stalled data read");
      else            rd_idx(8'h01, "R2 stalled index read");
    end
    drain();
    stall_mode = 1'b0;
    // R3: index write ends the ID sequence; strap 31 tables
    do_reset(5'd31);
    chk("R1 strap31 enables", {par_en, ser_en, fdc_en, ide_en}, 5'b00000);
    chk("R1 strap31 par_base", par_base, 16'h0378);
    chk("R1 strap31 par_irq", par_irq, 4'd5);
    chk_ser("R1 strap31 ser1", 1, 16'h02F8, 4'd3);
    wr_idx(8'h02);
    rd_idx(8'h02, "R3 index write skips id bytes");
    rd_dat(8'h02, "R1 strap31 power");
    wr_idx(8'h01); rd_dat(8'h10, "R1 strap31 address");
    // R1: strap 11
    do_reset(5'd11);
    chk("R7 strap11 ser_en", ser_en, 2'b01);
    chk_ser("R1 strap11 ser0", 0, 16'h03E8, 4'd4);
    rd_idx(8'h88, "R3 id byte after second reset");
    rd_idx(8'h00, "R3 second id after second reset");
    rd_dat(8'h4B, "R1 strap11 enable");
    wr_idx(8'h01); rd_dat(8'h08, "R1 strap11 address");
    drain();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule